// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block keeps the sticky exception record of a floating-point unit. Each cycle the arithmetic datapath can present a five-bit exception vector (invalid operation, divide-by-zero, overflow, underflow, inexact) with a valid strobe. The register ORs each reported event into its flags. A flag stays set until software writes the whole register. Each exception kind has a trap enable. When an enabled exception is accumulated, the block emits a one-cycle trap request that names a single cause.

Software writes the register through a write port that replaces the flags, the trap enables and a compare-mode control bit. The current word is always visible on a read port. The compare-mode bit is also brought out as its own output, so that the flag-setting logic of a compare unit can choose how an unordered result maps onto its carry flag.

Top module: `fp_exc_status`

## Requirements
- R1: After reset the read word is zero, the compare-mode output is low and no trap request is raised.
- R2: The flags sit in the read word as follows: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. The input exception vector uses the same bit order. An exception reported with the valid strobe sets its flag on the next clock edge.
- R3: Flags are sticky. Later exceptions and idle cycles never clear a flag. Only a software write changes a set flag.
- R4: A write replaces the whole register. Write bits 4:0 give the flags, bits 20:16 give the trap enables (same order as the flags) and bit 12 gives the compare-mode bit. Every other read bit returns zero. The compare-mode output follows bit 12.
- R5: An overflow accumulated while the overflow enable (bit 18) is clear also sets the inexact flag. The same holds for an underflow while the underflow enable (bit 19) is clear. While the matching enable is set, no inexact flag is implied.
- R6: When an accumulated exception has its enable set, the trap request is high for exactly one cycle. It rises on the same edge that sets the flag, and its cause vector is one-hot in the flag bit order.
- R7: When several enabled causes occur together, only one is reported. The order from highest to lowest is invalid, divide-by-zero, overflow, underflow, inexact, so an overflow or underflow trap always beats an inexact trap.
- R8: An exception whose enable is clear sets its flag but raises no trap request.
- R9: A write in the same cycle as an exception takes effect first. The exception is merged one cycle later, against the newly written enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | Exception vector is valid this cycle |
| exc_vec | input | 5 | Exception kinds raised by one operation |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write word |
| rd_data | output | 32 | Current register word |
| ac_mode | output | 1 | Compare-mode control bit |
| trap_valid | output | 1 | One-cycle trap request |
| trap_cause | output | 5 | One-hot cause of the trap request |

## Verification
The bench targets three groups of cases. The first is the implied inexact flag: overflow and underflow with their enables cleared and with them set. A design that forced inexact always, or never, shows the wrong flag word. The second is a combination of enabled causes. A design with a wrong precedence reports inexact or a lower-ranked cause instead of overflow or underflow. The last is a write that collides with an exception. A design that let the exception win, or dropped it, shows flags after the write, or never shows them at all, or traps against the old enables.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int unsigned NEXC = 5;

    typedef enum int unsigned {
        EX_INV = 0,
        EX_DVZ = 1,
        EX_OFL = 2,
        EX_UFL = 3,
        EX_INX = 4
    } exc_idx_e;

    typedef logic [NEXC-1:0] exc_vec_t;

    typedef struct packed {
        logic     ac;
        exc_vec_t enables;
        exc_vec_t flags;
    } fpx_state_t;

    // Add the inexact event implied by an untrapped overflow or underflow.
    function automatic exc_vec_t add_implied(exc_vec_t raw, exc_vec_t en);
        exc_vec_t res;
        res = raw;
        if ((raw[EX_OFL] && !en[EX_OFL]) || (raw[EX_UFL] && !en[EX_UFL]))
            res[EX_INX] = 1'b1;
        return res;
    endfunction

    // Keep only the lowest-numbered set bit (highest precedence).
    function automatic exc_vec_t pick_first(exc_vec_t q);
        exc_vec_t res;
        logic     found;
        res   = '0;
        found = 1'b0;
        for (int i = 0; i < int'(NEXC); i++) begin
            if (q[i] && !found) begin
                res[i] = 1'b1;
                found  = 1'b1;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/fpx_defer.sv
module fpx_defer
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     exc_valid,
    input  exc_vec_t exc_vec,
    input  logic     wr_en,
    output logic     merge_valid,
    output exc_vec_t merge_vec
);
    logic     pend_valid;
    exc_vec_t pend_vec;
    logic     any_event;

    always_comb begin
        merge_vec   = pend_vec | (exc_valid ? exc_vec : '0);
        any_event   = pend_valid | exc_valid;
        merge_valid = any_event & ~wr_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_vec   <= '0;
        end else if (wr_en) begin
            pend_valid <= any_event;
            pend_vec   <= merge_vec;
        end else begin
            pend_valid <= 1'b0;
            pend_vec   <= '0;
        end
    end
endmodule

// File: rtl/fpx_qualify.sv
module fpx_qualify
    import fpx_pkg::*;
(
    input  exc_vec_t raw_vec,
    input  exc_vec_t enables,
    output exc_vec_t eff_vec,
    output logic     trap_hit,
    output exc_vec_t trap_pick
);
    exc_vec_t armed;

    always_comb begin
        eff_vec   = add_implied(raw_vec, enables);
        armed     = eff_vec & enables;
        trap_hit  = |armed;
        trap_pick = pick_first(armed);
    end
endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
    import fpx_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned AC_POS = 12,
    parameter int unsigned EN_LSB = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [4:0]        exc_vec,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              ac_mode,
    output logic              trap_valid,
    output logic [4:0]        trap_cause
);
    localparam int unsigned EN_MSB = EN_LSB + NEXC - 1;

    fpx_state_t state_q;
    logic       merge_valid;
    exc_vec_t   merge_vec;
    exc_vec_t   eff_vec;
    logic       trap_hit;
    exc_vec_t   trap_pick;
    fpx_state_t wr_state;

    fpx_defer i_defer (
        .clk        (clk),
        .rst        (rst),
        .exc_valid  (exc_valid),
        .exc_vec    (exc_vec),
        .wr_en      (wr_en),
        .merge_valid(merge_valid),
        .merge_vec  (merge_vec)
    );

    fpx_qualify i_qual (
        .raw_vec  (merge_vec),
        .enables  (state_q.enables),
        .eff_vec  (eff_vec),
        .trap_hit (trap_hit),
        .trap_pick(trap_pick)
    );

    always_comb begin
        wr_state.flags   = wr_data[NEXC-1:0];
        wr_state.enables = wr_data[EN_MSB:EN_LSB];
        wr_state.ac      = wr_data[AC_POS];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= '0;
            trap_valid <= 1'b0;
            trap_cause <= '0;
        end else if (wr_en) begin
            state_q    <= wr_state;
            trap_valid <= 1'b0;
            trap_cause <= '0;
        end else if (merge_valid) begin
            state_q.flags <= state_q.flags | eff_vec;
            trap_valid    <= trap_hit;
            trap_cause    <= trap_pick;
        end else begin
            trap_valid <= 1'b0;
            trap_cause <= '0;
        end
    end

    always_comb begin
        rd_data                 = '0;
        rd_data[NEXC-1:0]       = state_q.flags;
        rd_data[EN_MSB:EN_LSB]  = state_q.enables;
        rd_data[AC_POS]         = state_q.ac;
        ac_mode                 = state_q.ac;
    end
endmodule

// File: rtl/fpx_status_checks.sv
module fpx_status_checks #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned AC_POS = 12,
    parameter int unsigned EN_LSB = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic              trap_valid,
    input logic [4:0]        trap_cause
);
    localparam logic [WORD_W-1:0] LIVE_MASK =
        (WORD_W'(5'h1F) << EN_LSB) | (WORD_W'(1) << AC_POS) | WORD_W'(5'h1F);

    logic [4:0] en_now;
    assign en_now = rd_data[EN_LSB +: 5];

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

    a_r4_write_replaces: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == ($past(wr_data) & LIVE_MASK));

    a_r3_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_data[4:0] & $past(rd_data[4:0])) == $past(rd_data[4:0]));

    a_r6_cause_onehot: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> $countones(trap_cause) == 1);

    a_r6_cause_flagged: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (rd_data[4:0] & trap_cause) == trap_cause);

    a_r8_cause_enabled: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_cause & $past(en_now)) != '0);

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |-> trap_cause == '0);
endmodule

bind fp_exc_status fpx_status_checks #(
    .WORD_W(WORD_W),
    .AC_POS(AC_POS),
    .EN_LSB(EN_LSB)
) i_checks (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .trap_valid(trap_valid),
    .trap_cause(trap_cause)
);

// File: tb/test_fp_exc_status.sv
`timescale 1ns/1ps
module test_fp_exc_status;
    logic        clk = 1'b0;
    logic        rst;
    logic        exc_valid;
    logic [4:0]  exc_vec;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        ac_mode;
    logic        trap_valid;
    logic [4:0]  trap_cause;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp_exc_status i_fp_exc_status (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_vec(exc_vec),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ac_mode(ac_mode),
        .trap_valid(trap_valid), .trap_cause(trap_cause)
    );

    // Vector table: config write, exception, expected flags, trap, cause.
    localparam int NV = 9;
    localparam logic [31:0] V_CFG [NV] = '{32'h0, 32'h0, 32'h0004_0000, 32'h0,
        32'h001F_0000, 32'h0010_0000, 32'h001F_0000, 32'h0018_0000, 32'h0002_0000};
    localparam logic [4:0] V_EXC [NV] = '{5'b00001, 5'b00100, 5'b00100, 5'b01000,
        5'b10100, 5'b00100, 5'b00011, 5'b11010, 5'b00001};
    localparam logic [4:0] V_FLG [NV] = '{5'b00001, 5'b10100, 5'b00100, 5'b11000,
        5'b10100, 5'b10100, 5'b00011, 5'b11010, 5'b00001};
    localparam logic V_TV [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    localparam logic [4:0] V_CAU [NV] = '{5'b0, 5'b0, 5'b00100, 5'b0,
        5'b00100, 5'b10000, 5'b00001, 5'b01000, 5'b0};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        exc_valid = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic do_write(logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        tick();
    endtask

    task automatic do_exc(logic [4:0] v);
        exc_valid = 1'b1; exc_vec = v;
        tick();
    endtask

    initial begin
        rst = 1'b1; exc_valid = 1'b0; exc_vec = '0; wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 ac_mode", 32'(ac_mode), 32'h0);
        check("R1 trap_valid", 32'(trap_valid), 32'h0);

        // Table: R2 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            do_write(V_CFG[i]);
            do_exc(V_EXC[i]);
            check($sformatf("R2/R5 flags vec%0d", i), 32'(rd_data[4:0]), 32'(V_FLG[i]));
            check($sformatf("R6/R8 trap vec%0d", i), 32'(trap_valid), 32'(V_TV[i]));
            check($sformatf("R7 cause vec%0d", i), 32'(trap_cause), 32'(V_CAU[i]));
            tick();
            check($sformatf("R6 single pulse vec%0d", i), 32'(trap_valid), 32'h0);
        end

        // R3 sticky accumulation
        do_write(32'h0);
        do_exc(5'b00001);
        do_exc(5'b00010);
        tick(); tick();
        check("R3 sticky flags", 32'(rd_data[4:0]), 32'h3);
        do_exc(5'b00000);
        check("R3 empty event keeps flags", 32'(rd_data[4:0]), 32'h3);

        // R4 write replaces, reserved bits zero
        do_write(32'hFFFF_FFFF);
        check("R4 masked read", rd_data, 32'h001F_101F);
        check("R4 ac_mode", 32'(ac_mode), 32'h1);
        do_write(32'h0000_1000);
        check("R4 write clears flags", rd_data, 32'h0000_1000);

        // R9 write collides with exception
        wr_en = 1'b1; wr_data = 32'h0001_0000;
        exc_valid = 1'b1; exc_vec = 5'b00001;
        tick();
        check("R9 write wins", rd_data, 32'h0001_0000);
        check("R9 no trap yet", 32'(trap_valid), 32'h0);
        tick();
        check("R9 merged flag", rd_data, 32'h0001_0001);
        check("R9 trap on new enable", 32'(trap_valid), 32'h1);
        check("R9 cause", 32'(trap_cause), 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule